// File: doc/BRIEF.md
# Stepping Trim Wiper Controller

This block is the digital core of a nonvolatile trimming potentiometer. It holds an 8-bit wiper code that selects one of 256 taps on an external resistor-string converter. Each tap is 1/256 of the span between the two references. A host adjusts the code through three pins: an active-low select, an increment strobe that acts on its falling edge, and a direction level.

When the host deselects the part, the level of the strobe at that moment decides what happens. If the strobe is high, the current code is committed to a modelled nonvolatile register. That write holds a busy flag for a parameterised number of clock cycles, which stands for the 5 ms write time. If the strobe is low, the adjustment is discarded. At power-up the wiper is loaded from the nonvolatile register.

The controller is a four-state machine:
- RECALL: entered on power-on reset; it loads the stored code and goes on to STANDBY.
- STANDBY: select is high. It goes to ACTIVE when select falls.
- ACTIVE: strobe edges step the code. When select rises it goes to WRITE if the strobe is high, or back to STANDBY if the strobe is low.
- WRITE: it waits out the busy timer. It then returns to STANDBY or ACTIVE, following the select level at that time.

Top module: `trim_wiper_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low) is released, `wiper` equals the stored nonvolatile code within 6 clock cycles. The stored code is `NV_INIT` (default 8'h80) until the first commit.
- R2: While `sel_n` is low, a falling edge on `inc` with `dir` high increments `wiper` by one.
- R3: While `sel_n` is low, a falling edge on `inc` with `dir` low decrements `wiper` by one.
- R4: The code saturates: it stays at 8'hFF when stepped up from 8'hFF, and at 8'h00 when stepped down from 8'h00.
- R5: While `sel_n` is high, falling edges on `inc` are ignored and `wiper` holds its value.
- R6: A rise of `sel_n` while `inc` is high commits `wiper` to the nonvolatile register. `busy` is then high for exactly `WRITE_CYCLES` clock cycles, and the committed code is what the next power-up recalls.
- R7: A rise of `sel_n` while `inc` is low leaves `busy` low and stores nothing, so the next power-up restores the previously stored code.
- R8: While a write is in progress, strobe edges and select changes are ignored and `wiper` does not change.
- R9: A rising edge on `inc` never moves the code.
- R10: While `por_n` is low, `wiper` reads 8'h00 and `busy` reads 0. Select, strobe and direction are held high internally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| sel_n | input | 1 | Select, active low, asynchronous to clk |
| inc | input | 1 | Increment strobe; a falling edge steps the code |
| dir | input | 1 | Direction: 1 steps up, 0 steps down |
| wiper | output | 8 | Current wiper code for the converter |
| busy | output | 1 | High while a nonvolatile write is in progress |

## Verification
The bench goes after the commit-or-discard decision taken at deselect. A design that sampled the strobe one cycle late, or that ignored its level, would store a discarded setting, and a later power cycle would expose it. It steps the code into both rails. A wrapping counter would jump from 8'hFF to 8'h00, or the other way, and break the saturation checks. It toggles select and the strobe in the middle of a write. A design that kept listening while busy would move the wiper or start a second write. It also measures the busy window exactly and confirms that rising strobe edges never step the code.

// File: rtl/trim_pkg.sv
package trim_pkg;

    localparam int CODE_W = 8;

    // Controller states
    typedef enum logic [1:0] {
        S_RECALL  = 2'd0,
        S_STANDBY = 2'd1,
        S_ACTIVE  = 2'd2,
        S_WRITE   = 2'd3
    } wiper_state_e;

endpackage

// File: rtl/trim_sync.sv
// Two-flop synchroniser, one chain per bit; reset forces the reset value.
module trim_sync #(
    parameter int              WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                stab_q <= RST_VAL[b];
            end else begin
                meta_q <= d[b];
                stab_q <= meta_q;
            end
        end

        assign q[b] = stab_q;
    end

endmodule

// File: rtl/trim_step.sv
// Saturating one-step up/down of the wiper code.
module trim_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] code,
    input  logic         en,
    input  logic         up,
    output logic [W-1:0] next
);

    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] BOT = '0;

    always_comb begin
        next = code;
        if (en) begin
            if (up) begin
                if (code != TOP) next = code + 1'b1;
            end else begin
                if (code != BOT) next = code - 1'b1;
            end
        end
    end

endmodule

// File: rtl/trim_nvm.sv
// Behavioural nonvolatile code register with a write-busy timer.
// The storage register is not cleared by reset, so it survives a power cycle.
module trim_nvm #(
    parameter int           W            = 8,
    parameter int           WRITE_CYCLES = 625_000,
    parameter logic [W-1:0] NV_INIT      = 8'h80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_start,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] nv_data,
    output logic         wr_busy
);

    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES);

    logic [W-1:0]     nv_q = NV_INIT;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (wr_start && !wr_busy) begin
            nv_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_start && !wr_busy) begin
            cnt_q <= CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign nv_data = nv_q;
    assign wr_busy = (cnt_q != '0);

endmodule

// File: rtl/trim_wiper_ctrl.sv
// Top: pin synchronisation, control state machine and wiper register.
module trim_wiper_ctrl #(
    parameter int                            CODE_W       = trim_pkg::CODE_W,
    parameter int                            WRITE_CYCLES = 625_000,
    parameter logic [trim_pkg::CODE_W-1:0]   NV_INIT      = 8'h80
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sel_n,
    input  logic              inc,
    input  logic              dir,
    output logic [CODE_W-1:0] wiper,
    output logic              busy
);

    import trim_pkg::*;

    localparam int NPIN = 3;

    // Synchronised pins: [2]=select, [1]=strobe, [0]=direction; all idle high.
    logic [NPIN-1:0] pins_s;
    logic            sel_n_s;
    logic            inc_s;
    logic            dir_s;
    logic            inc_d;
    logic            inc_fall;

    trim_sync #(
        .WIDTH   (NPIN),
        .RST_VAL ({NPIN{1'b1}})
    ) i_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     ({sel_n, inc, dir}),
        .q     (pins_s)
    );

    assign sel_n_s = pins_s[2];
    assign inc_s   = pins_s[1];
    assign dir_s   = pins_s[0];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) inc_d <= 1'b1;
        else        inc_d <= inc_s;
    end

    assign inc_fall = inc_d & ~inc_s;

    // State machine
    wiper_state_e      state_q;
    wiper_state_e      state_d;
    logic              step_en;
    logic              wr_start;
    logic              load_nv;
    logic              wr_busy;
    logic [CODE_W-1:0] nv_data;
    logic [CODE_W-1:0] wiper_q;
    logic [CODE_W-1:0] wiper_step;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= S_RECALL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RECALL:  state_d = S_STANDBY;
            S_STANDBY: if (!sel_n_s) state_d = S_ACTIVE;
            S_ACTIVE: begin
                if (sel_n_s) state_d = inc_s ? S_WRITE : S_STANDBY;
            end
            S_WRITE: begin
                if (!wr_busy) state_d = sel_n_s ? S_STANDBY : S_ACTIVE;
            end
            default:   state_d = S_RECALL;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        step_en  = 1'b0;
        wr_start = 1'b0;
        load_nv  = 1'b0;
        unique case (state_q)
            S_RECALL:  load_nv = 1'b1;
            S_STANDBY: ;
            S_ACTIVE: begin
                if (sel_n_s)       wr_start = inc_s;
                else if (inc_fall) step_en  = 1'b1;
            end
            S_WRITE:   ;
            default:   ;
        endcase
    end

    trim_step #(
        .W (CODE_W)
    ) i_step (
        .code (wiper_q),
        .en   (step_en),
        .up   (dir_s),
        .next (wiper_step)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       wiper_q <= '0;
        else if (load_nv) wiper_q <= nv_data;
        else              wiper_q <= wiper_step;
    end

    trim_nvm #(
        .W            (CODE_W),
        .WRITE_CYCLES (WRITE_CYCLES),
        .NV_INIT      (NV_INIT)
    ) i_nvm (
        .clk      (clk),
        .rst_n    (por_n),
        .wr_start (wr_start),
        .wr_data  (wiper_q),
        .nv_data  (nv_data),
        .wr_busy  (wr_busy)
    );

    assign wiper = wiper_q;
    assign busy  = wr_busy;

endmodule

// File: rtl/trim_wiper_chk.sv
// Property checker, bound to the top module.
module trim_wiper_chk #(
    parameter int W = 8
) (
    input logic                   clk,
    input logic                   por_n,
    input trim_pkg::wiper_state_e state,
    input logic [W-1:0]           wiper,
    input logic [W-1:0]           nv,
    input logic                   busy
);

    import trim_pkg::*;

    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!por_n)
        (state == S_ACTIVE) |=> (W'(wiper - $past(wiper)) inside {W'(0), W'(1), {W{1'b1}}})); // R2

    AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!por_n)
        (state == S_ACTIVE && wiper == {W{1'b1}}) |=> (wiper != '0)); // R4

    AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!por_n)
        (state == S_ACTIVE && wiper == '0) |=> (wiper != {W{1'b1}})); // R4

    AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (state == S_STANDBY) |=> $stable(wiper)); // R5

    AST_COMMIT_DATA: assert property (@(posedge clk) disable iff (!por_n)
        $rose(busy) |-> (nv == wiper)); // R6

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        busy |=> $stable(wiper)); // R8

    AST_RESET_VALUES: assert property (@(posedge clk)
        !por_n |-> (wiper == '0 && !busy)); // R10

endmodule

bind trim_wiper_ctrl trim_wiper_chk #(
    .W (CODE_W)
) i_chk (
    .clk   (clk),
    .por_n (por_n),
    .state (state_q),
    .wiper (wiper_q),
    .nv    (nv_data),
    .busy  (wr_busy)
);

// File: tb/test_trim_wiper_ctrl.sv
`timescale 1ns/1ps
module test_trim_wiper_ctrl;

    localparam int WCYC = 40;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       sel_n = 1'b1;
    logic       inc = 1'b1;
    logic       dir = 1'b1;
    logic [7:0] wiper;
    logic       busy;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    trim_wiper_ctrl #(
        .CODE_W       (8),
        .WRITE_CYCLES (WCYC),
        .NV_INIT      (8'h80)
    ) i_trim_wiper_ctrl (
        .clk   (clk),
        .por_n (por_n),
        .sel_n (sel_n),
        .inc   (inc),
        .dir   (dir),
        .wiper (wiper),
        .busy  (busy)
    );

    // Stimulus table: {direction, pulse count, expected code}
    localparam logic [16:0] VECS [0:5] = '{
        {1'b1, 8'd1, 8'h81},
        {1'b1, 8'd3, 8'h84},
        {1'b0, 8'd2, 8'h82},
        {1'b0, 8'd1, 8'h81},
        {1'b1, 8'd5, 8'h86},
        {1'b0, 8'd4, 8'h82}
    };

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic up);
        dir = up;
        wait_n(2);
        inc = 1'b0;
        wait_n(5);
        inc = 1'b1;
        wait_n(5);
    endtask

    task automatic power_cycle();
        por_n = 1'b0;
        wait_n(3);
        check("R10 wiper in reset", wiper, 8'h00);
        check("R10 busy in reset", busy, 0);
        por_n = 1'b1;
        wait_n(6);
    endtask

    initial begin
        int bcnt;
        @(negedge clk);
        // Reset state
        wait_n(2);
        check("R10 wiper in reset", wiper, 8'h00);
        check("R10 busy in reset", busy, 0);
        por_n = 1'b1;
        wait_n(6);
        check("R1 initial recall", wiper, 8'h80);

        // Table walk while selected: R2 up, R3 down
        sel_n = 1'b0;
        wait_n(6);
        for (int v = 0; v < 6; v++) begin
            for (int p = 0; p < int'(VECS[v][15:8]); p++) pulse(VECS[v][16]);
            check(VECS[v][16] ? "R2 step up" : "R3 step down", wiper, VECS[v][7:0]);
        end

        // R9: falling edge steps, rising edge does not
        dir = 1'b1;
        wait_n(2);
        inc = 1'b0;
        wait_n(5);
        check("R2 falling edge", wiper, 8'h83);
        inc = 1'b1;
        wait_n(5);
        check("R9 rising edge no step", wiper, 8'h83);

        // R7: deselect with strobe low discards
        inc = 1'b0;
        wait_n(5);
        check("R2 step before discard", wiper, 8'h84);
        sel_n = 1'b1;
        wait_n(6);
        check("R7 no write busy", busy, 0);
        inc = 1'b1;
        wait_n(4);
        power_cycle();
        check("R7 recall of old code", wiper, 8'h80);

        // R5: edges ignored while deselected
        pulse(1'b1);
        pulse(1'b1);
        pulse(1'b0);
        check("R5 standby hold", wiper, 8'h80);

        // R6: commit, exact busy window, recall
        sel_n = 1'b0;
        wait_n(6);
        pulse(1'b1);
        pulse(1'b1);
        check("R2 before commit", wiper, 8'h82);
        sel_n = 1'b1;
        bcnt = 0;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (busy) bcnt++;
            else if (bcnt > 0) break;
        end
        check("R6 busy length", bcnt, WCYC);
        power_cycle();
        check("R6 recall committed", wiper, 8'h82);

        // R8: activity during a write is ignored
        sel_n = 1'b0;
        wait_n(6);
        pulse(1'b1);
        sel_n = 1'b1;
        wait_n(4);
        check("R6 busy after commit", busy, 1);
        sel_n = 1'b0;
        wait_n(3);
        inc = 1'b0;
        wait_n(3);
        inc = 1'b1;
        wait_n(3);
        sel_n = 1'b1;
        wait_n(3);
        check("R8 busy still high", busy, 1);
        wait_n(WCYC + 10);
        check("R8 no step while busy", wiper, 8'h83);
        check("R8 busy done", busy, 0);
        power_cycle();
        check("R8 recall", wiper, 8'h83);

        // R4: saturation at both rails
        sel_n = 1'b0;
        wait_n(6);
        for (int p = 0; p < 130; p++) pulse(1'b1);
        check("R4 top rail", wiper, 8'hFF);
        pulse(1'b1);
        check("R4 top rail held", wiper, 8'hFF);
        for (int p = 0; p < 260; p++) pulse(1'b0);
        check("R4 bottom rail", wiper, 8'h00);
        pulse(1'b0);
        check("R4 bottom rail held", wiper, 8'h00);
        sel_n = 1'b0;
        inc = 1'b0;
        wait_n(2);
        sel_n = 1'b1;
        wait_n(6);
        inc = 1'b1;
        power_cycle();
        check("R7 recall after discard", wiper, 8'h83);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule